// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Hit and Miss Counters

This block places a four-line direct-mapped byte cache between a requester and a slower backing memory. A request arrives as one packed 14-bit word that carries a data byte and a 6-bit address, qualified by a valid strobe and a write flag. For a read, the addressed line is compared against the request tag. A match returns the cached byte one cycle later. A mismatch fetches the byte over a request/acknowledge memory port, installs it in the line and then returns it. Writes go through to the backing memory and refresh the cached copy only when that copy is already present.

Two saturating counters track read hits and read misses, so the hit ratio of any access sequence can be worked out from them. The controller is a three-state machine. In IDLE it accepts requests. IDLE to IDLE covers a read hit or a request-free cycle. IDLE to FILL happens on a read miss. IDLE to WRITE happens on any write. FILL to IDLE and WRITE to IDLE are each taken on the cycle the memory acknowledges. `req_ready` is high only in IDLE, and this holds the requester off during memory traffic.

Top module: `dmc_top`

## Requirements
- R1: Request word layout: bits 13:6 hold the data byte and bits 5:0 hold the address. Address bits 5:2 form the tag and bits 1:0 select one of 4 lines. The data field is ignored for reads.
- R2: Reset clears every line's valid bit and both counters to 0. After reset `req_ready` is 1 and `rsp_valid` and `mem_req` are 0. A line whose valid bit is clear never hits, whatever its stored tag.
- R3: A read hit raises `rsp_valid` with `rsp_hit`=1 and the cached byte in the cycle after acceptance. It raises no `mem_req`.
- R4: A read miss raises `mem_req` with `mem_we`=0 and the request address. `mem_req` and the address stay stable until `mem_ack`, at any latency, and `req_ready` stays 0 meanwhile.
- R5: On the acknowledge of a fill, the fetched byte, the tag and the valid bit are written into the line. `rsp_valid` rises with `rsp_hit`=0 and that byte in the next cycle, with `req_ready` back at 1.
- R6: A miss to an occupied line replaces its contents, and a later read of the displaced address misses.
- R7: A write raises `mem_req` with `mem_we`=1, the address and the data byte until `mem_ack`. It produces no response and leaves both counters unchanged.
- R8: A write whose line is valid with a matching tag updates the cached byte. A write that misses does not allocate the line.
- R9: The hit counter counts read hits and the miss counter counts read misses. Each saturates at 2^CNT_W-1 (16 bits by default).
- R10: A request accepted in the same cycle that a fill response is presented looks up the line state that the fill has just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_we | input | 1 | 1 = write request, 0 = read |
| req_word | input | 14 | Packed request {data[7:0], address[5:0]} |
| req_ready | output | 1 | Request accepted when high with req_valid |
| rsp_valid | output | 1 | Read response strobe, one cycle |
| rsp_hit | output | 1 | Response came from a hit |
| rsp_data | output | 8 | Read byte |
| mem_req | output | 1 | Backing memory request |
| mem_we | output | 1 | Backing memory write |
| mem_addr | output | 6 | Backing memory address |
| mem_wdata | output | 8 | Backing memory write byte |
| mem_ack | input | 1 | Backing memory acknowledge, one cycle |
| mem_rdata | input | 8 | Backing memory read byte, valid with mem_ack |
| hit_count | output | 16 | Saturating read-hit count |
| miss_count | output | 16 | Saturating read-miss count |

## Verification
The fill response of a miss and the lookup of the next request can share a cycle. The bench provokes this by issuing a new read on the very cycle `rsp_valid` appears for a miss, often to the address just filled, and expects an immediate hit built from the freshly written tag and byte. A write hit also updates a line in the same cycle the memory write request starts. This is judged by reading the address back and expecting a hit that returns the new byte. Sweeps over all 64 addresses and a long pseudo-random sequence, run at varied memory latencies, compare every response and both counters with an arithmetic reference model, including the point where the counters saturate.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
    parameter int TAG_W  = 4,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_index,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]             valid_vec;
    logic [LINES-1:0][TAG_W-1:0]  tag_vec;
    logic [LINES-1:0][DATA_W-1:0] data_vec;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic              valid_r;
        logic [TAG_W-1:0]  tag_r;
        logic [DATA_W-1:0] data_r;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_r <= 1'b0;
                tag_r   <= '0;
                data_r  <= '0;
            end else if (wr_en && (wr_index == IDX_W'(g))) begin
                valid_r <= 1'b1;
                tag_r   <= wr_tag;
                data_r  <= wr_data;
            end
        end
        assign valid_vec[g] = valid_r;
        assign tag_vec[g]   = tag_r;
        assign data_vec[g]  = data_r;
    end

    always_comb begin
        lk_hit  = valid_vec[lk_index] && (tag_vec[lk_index] == lk_tag);
        lk_data = data_vec[lk_index];
    end

    // R5
    line_install_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_vec[$past(wr_index)] && tag_vec[$past(wr_index)] == $past(wr_tag)
                  && data_vec[$past(wr_index)] == $past(wr_data));
endmodule

// File: rtl/dmc_sat_counter.sv
module dmc_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc && count != TOP)
            count <= count + 1'b1;
    end

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == TOP) |=> (count == TOP));
    // R9
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && count != TOP) |=> (count == $past(count) + 1'b1));
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count));
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    input  logic              lk_hit,
    input  logic [DATA_W-1:0] lk_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              hit_inc,
    output logic              miss_inc
);
    ctl_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              accept, fill_done, write_hit;

    assign accept = req_valid && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = req_we ? ST_WRITE : (lk_hit ? ST_IDLE : ST_FILL);
            ST_FILL:  if (mem_ack) state_d = ST_IDLE;
            ST_WRITE: if (mem_ack) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            data_q <= req_data;
        end
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mem_req   = (state_q != ST_IDLE);
        mem_we    = (state_q == ST_WRITE);
        mem_addr  = addr_q;
        mem_wdata = data_q;
        fill_done = (state_q == ST_FILL) && mem_ack;
        write_hit = accept && req_we && lk_hit;
        wr_en     = fill_done || write_hit;
        wr_addr   = fill_done ? addr_q : req_addr;
        wr_data   = fill_done ? mem_rdata : req_data;
        hit_inc   = accept && !req_we && lk_hit;
        miss_inc  = accept && !req_we && !lk_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= hit_inc || fill_done;
            if (hit_inc) begin
                rsp_hit  <= 1'b1;
                rsp_data <= lk_data;
            end else if (fill_done) begin
                rsp_hit  <= 1'b0;
                rsp_data <= mem_rdata;
            end
        end
    end

    // R3
    hit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_we && lk_hit) |=> (rsp_valid && rsp_hit && !mem_req));
    // R4
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    // R4
    ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);
    // R5
    fill_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> (rsp_valid && !rsp_hit && req_ready
                                             && rsp_data == $past(mem_rdata)));
    // R7
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (!rsp_valid && req_ready));
endmodule

// File: rtl/dmc_top.sv
module dmc_top #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 2,
    parameter int CNT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_we,
    input  logic [ADDR_W+DATA_W-1:0] req_word,
    output logic                     req_ready,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic [DATA_W-1:0]        rsp_data,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    input  logic                     mem_ack,
    input  logic [DATA_W-1:0]        mem_rdata,
    output logic [CNT_W-1:0]         hit_count,
    output logic [CNT_W-1:0]         miss_count
);
    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam int WORD_W = ADDR_W + DATA_W;

    logic [ADDR_W-1:0] req_addr, wr_addr;
    logic [DATA_W-1:0] req_data, lk_data, wr_data;
    logic              lk_hit, wr_en, hit_inc, miss_inc;

    assign req_addr = req_word[ADDR_W-1:0];
    assign req_data = req_word[WORD_W-1:ADDR_W];

    dmc_line_store #(.TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .lk_index(req_addr[IDX_W-1:0]), .lk_tag(req_addr[ADDR_W-1:IDX_W]),
        .lk_hit(lk_hit), .lk_data(lk_data),
        .wr_en(wr_en), .wr_index(wr_addr[IDX_W-1:0]), .wr_tag(wr_addr[ADDR_W-1:IDX_W]),
        .wr_data(wr_data)
    );

    dmc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr), .req_data(req_data),
        .req_ready(req_ready), .lk_hit(lk_hit), .lk_data(lk_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .hit_inc(hit_inc), .miss_inc(miss_inc)
    );

    dmc_sat_counter #(.W(CNT_W)) hit_ctr_i  (.clk(clk), .rst_n(rst_n), .inc(hit_inc),  .count(hit_count));
    dmc_sat_counter #(.W(CNT_W)) miss_ctr_i (.clk(clk), .rst_n(rst_n), .inc(miss_inc), .count(miss_count));

    // R9
    one_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_inc && miss_inc));
endmodule

// File: tb/dmc_top_tb_top.sv
`timescale 1ns/1ps
module dmc_top_tb_top;
    localparam int CW  = 5;
    localparam int SAT = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_we = 1'b0;
    logic [13:0] req_word = '0;
    logic req_ready, rsp_valid, rsp_hit, mem_req, mem_we;
    logic [7:0] rsp_data, mem_wdata;
    logic [5:0] mem_addr;
    logic mem_ack = 1'b0;
    logic [7:0] mem_rdata = '0;
    logic [CW-1:0] hit_count, miss_count;

    always #2.5 clk = ~clk;

    dmc_top #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we), .req_word(req_word),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .hit_count(hit_count), .miss_count(miss_count)
    );

    int total = 0, failed = 0;
    logic [7:0] bmem [64];
    logic [7:0] ref_mem [64];
    logic [3:0] m_tag [4];
    logic       m_valid [4];
    int exp_hits = 0, exp_miss = 0;
    int mem_lat = 0, lat_cnt = 0;

    // backing memory model: acknowledge after mem_lat idle cycles
    always @(posedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (lat_cnt >= mem_lat) begin
                mem_ack <= 1'b1;
                lat_cnt <= 0;
                if (mem_we) bmem[mem_addr] <= mem_wdata;
                else        mem_rdata <= bmem[mem_addr];
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_counts(input string req);
        check(hit_count == CW'(exp_hits), req, "hit_count", int'(hit_count), exp_hits);
        check(miss_count == CW'(exp_miss), req, "miss_count", int'(miss_count), exp_miss);
    endtask

    task automatic do_read(input logic [5:0] a, input string req);
        logic [1:0] idx;
        logic exp_hit;
        int n;
        idx = a[1:0];
        exp_hit = m_valid[idx] && (m_tag[idx] == a[5:2]);
        n = 0;
        while (!req_ready && n < 50) begin @(negedge clk); n++; end
        req_valid = 1'b1; req_we = 1'b0;
        req_word = {8'(a * 37 + 5), a};            // R1: data field ignored on reads
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        if (exp_hit) begin
            exp_hits = (exp_hits < SAT) ? exp_hits + 1 : SAT;
            check(rsp_valid && rsp_hit, {req, " R3"}, "hit response", {rsp_valid, rsp_hit}, 3);
            check(rsp_data == ref_mem[a], {req, " R3"}, "hit data", rsp_data, ref_mem[a]);
            check(!mem_req, {req, " R3"}, "mem_req on hit", mem_req, 0);
        end else begin
            exp_miss = (exp_miss < SAT) ? exp_miss + 1 : SAT;
            check(mem_req && !mem_we && !req_ready, {req, " R4"}, "fill request", {mem_req, mem_we, req_ready}, 4);
            check(mem_addr == a, {req, " R4"}, "fill address", mem_addr, a);
            n = 0;
            while (!rsp_valid && n < 50) begin
                @(negedge clk); n++;
                if (!rsp_valid) check(mem_req && mem_addr == a && !req_ready, {req, " R4"}, "fill hold", mem_addr, a);
            end
            check(rsp_valid && !rsp_hit && req_ready, {req, " R5"}, "fill response", {rsp_valid, rsp_hit, req_ready}, 5);
            check(rsp_data == ref_mem[a], {req, " R5"}, "fill data", rsp_data, ref_mem[a]);
            m_valid[idx] = 1'b1; m_tag[idx] = a[5:2];
        end
        check_counts({req, " R9"});
    endtask

    task automatic do_write(input logic [5:0] a, input logic [7:0] d, input string req);
        int n;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_word = {d, a};   // R1: {data, address}
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
        check(mem_req && mem_we, {req, " R7"}, "write request", {mem_req, mem_we}, 3);
        check(mem_addr == a && mem_wdata == d, {req, " R7"}, "write addr/data", {mem_addr, mem_wdata}, {a, d});
        n = 0;
        while (!req_ready && n < 50) begin
            check(!rsp_valid, {req, " R7"}, "response during write", rsp_valid, 0);
            @(negedge clk); n++;
        end
        check(!rsp_valid, {req, " R7"}, "response after write", rsp_valid, 0);
        check(bmem[a] == d, {req, " R7"}, "memory written", bmem[a], d);
        ref_mem[a] = d;
        check_counts({req, " R7"});
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin m_valid[i] = 1'b0; m_tag[i] = '0; end
        exp_hits = 0; exp_miss = 0;
        @(negedge clk);
        check(req_ready && !rsp_valid && !mem_req, "R2", "reset outputs", {req_ready, rsp_valid, mem_req}, 4);
        check_counts("R2");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; failed++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        for (int i = 0; i < 64; i++) begin
            bmem[i] = 8'(i * 29 + 11);
            ref_mem[i] = bmem[i];
        end
        @(negedge clk);
        apply_reset();

        // R2: stored tag is 0 after reset, but invalid line must miss
        do_read(6'd0, "R2");
        // R10: next request on the fill-response cycle hits the new line
        do_read(6'd0, "R10");

        // R1 R6: full sweep, each access evicts the previous tag of its line
        for (int a = 0; a < 64; a++) begin
            mem_lat = a % 4;
            do_read(6'(a), "R6");
        end
        for (int a = 60; a < 64; a++) do_read(6'(a), "R3");
        do_read(6'd1, "R6");                       // displaced earlier, must miss

        // R8: write hit refreshes cached byte, write miss does not allocate
        mem_lat = 2;
        do_write(6'd1, 8'hA5, "R8");
        do_read(6'd1, "R8");
        do_write(6'd5, 8'h3C, "R8");
        do_read(6'd1, "R8");
        do_read(6'd5, "R8");
        do_write(6'd0, 8'hFF, "R8");

        // R9: pseudo-random mix drives both counters into saturation
        lfsr = 8'h5B;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            mem_lat = i % 3;
            if (lfsr[7:6] == 2'b11) do_write({lfsr[3:2], lfsr[1:0] ^ 2'(i)}, lfsr ^ 8'(i), "R8");
            else                    do_read(6'({lfsr[3:2] ^ lfsr[5:4], lfsr[1:0]}), "R9");
        end
        check(hit_count == CW'(SAT), "R9", "hit saturated", int'(hit_count), SAT);
        check(miss_count == CW'(SAT), "R9", "miss saturated", int'(miss_count), SAT);

        // R2: mid-run reset invalidates cached lines
        do_read(6'd7, "R2");
        apply_reset();
        do_read(6'd7, "R2");
        do_read(6'd7, "R10");

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule